// File: doc/BRIEF.md
# Scalar Bit-Count and Compare-Select Unit

This block is one slice of a scalar arithmetic unit. It takes one operation per cycle and computes one of eight results. Four operations count bits: the number of ones or the number of zeros, in a 32-bit operand or in a 64-bit operand. The other four are selects that return the smaller or the larger of two 32-bit operands, compared either as two's-complement values or as unsigned values. Every operation also produces a one-bit condition flag. For the counting operations the flag is set when the count is nonzero. For the selects it is set when the strict comparison that chose the result holds.

The issue side drives an operation code, the operands and a valid strobe in the same cycle. The result, the flag and a result-valid strobe come out of registers on the next clock edge. A two-state controller tracks the output stage:
- **ST_IDLE**: no result is being presented.
- **ST_EMIT**: a result is presented on the outputs.

The controller has four transitions:
- **IDLE→EMIT** and **EMIT→EMIT**: an operation is accepted.
- **EMIT→IDLE**: no operation is accepted.
- **IDLE→IDLE**: the slice stays quiet.

When no operation is accepted, the destination and flag registers keep their last values.

Top module: `sclu_cntmm`

## Requirements
- R1: With op code 0, the unit counts the set bits of src0[31:0]. Bits src0[63:32] have no effect on the result.
- R2: With op code 1, the unit counts the set bits of all 64 bits of src0. The count is zero-extended into the 32-bit dst and can reach 64.
- R3: Op code 2 counts the cleared bits of src0[31:0]. Op code 3 counts the cleared bits of all 64 bits of src0. Each is the count of ones of the inverted operand.
- R4: For op codes 0 to 3, the flag is 1 exactly when the count is nonzero.
- R5: Op code 5 (signed) and op code 7 (unsigned) return the larger of src0[31:0] and src1. For these codes the flag is 1 only when src0 is strictly greater than src1.
- R6: Op code 4 (signed) and op code 6 (unsigned) return the smaller of src0[31:0] and src1. For these codes the flag is 1 only when src0 is strictly less than src1.
- R7: Op codes 4 and 5 compare the operands as two's-complement 32-bit values, and op codes 6 and 7 compare them as unsigned values. When the operands are equal, the result is src1 and the flag is 0.
- R8: An operation accepted with in_valid high appears on dst and flag one cycle later, together with out_valid high. When in_valid is low, out_valid is low in the next cycle.
- R9: While rst_n is low, out_valid, dst and flag are all 0.
- R10: A cycle with in_valid low leaves dst and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation accepted this cycle |
| op | input | 3 | Operation code (see R1 to R7) |
| src0 | input | 64 | First operand; the selects use only bits 31:0 |
| src1 | input | 32 | Second operand, used by the selects |
| out_valid | output | 1 | Result registers hold a fresh result |
| dst | output | 32 | Registered result |
| flag | output | 1 | Registered condition flag |

## Verification
The bench aims at the following cases, and each one catches a particular mistake:
- **Upper operand bits with the 32-bit counts.** Garbage is placed in src0[63:32]. A design that fails to mask these bits gives counts above 32.
- **Saturated counts.** An all-ones or all-zero 64-bit operand yields 64. A design that truncates the count shows 0 with a cleared flag.
- **Operands whose sign bit is set.** A signed/unsigned mix-up swaps the min and max results.
- **Equal operands.** A design using a non-strict compare sets the flag.
- **Idle gaps between operations.** A design that loads its registers without checking valid corrupts the held values, and one with the wrong latency shifts out_valid by a cycle.

// File: rtl/sclu_pkg.sv
package sclu_pkg;

    localparam int OPW = 3;

    // Operation codes; bit 2 separates counts from selects.
    typedef enum logic [OPW-1:0] {
        OP_ONES_N  = 3'd0,
        OP_ONES_W  = 3'd1,
        OP_ZEROS_N = 3'd2,
        OP_ZEROS_W = 3'd3,
        OP_SMIN    = 3'd4,
        OP_SMAX    = 3'd5,
        OP_UMIN    = 3'd6,
        OP_UMAX    = 3'd7
    } sclu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } sclu_st_e;

endpackage

// File: rtl/sclu_popcnt.sv
module sclu_popcnt #(
    parameter int W    = 64,
    parameter int LANE = 8,
    localparam int NL  = W / LANE,
    localparam int CW  = $clog2(W + 1),
    localparam int LCW = $clog2(LANE + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);

    logic [LCW-1:0] lane_cnt [NL];

    // One partial counter per lane.
    for (genvar g = 0; g < NL; g++) begin : g_lane
        always_comb begin
            lane_cnt[g] = '0;
            for (int b = 0; b < LANE; b++) begin
                lane_cnt[g] = lane_cnt[g] + LCW'(vec[g*LANE + b]);
            end
        end
    end

    // Sum the lane counts.
    always_comb begin
        count = '0;
        for (int l = 0; l < NL; l++) begin
            count = count + CW'(lane_cnt[l]);
        end
    end

endmodule

// File: rtl/sclu_minmax.sv
module sclu_minmax #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         use_signed,
    input  logic         pick_max,
    output logic [W-1:0] res,
    output logic         cond
);

    logic a_gt_b;
    logic a_lt_b;

    always_comb begin
        if (use_signed) begin
            a_gt_b = $signed(a) > $signed(b);
            a_lt_b = $signed(a) < $signed(b);
        end else begin
            a_gt_b = a > b;
            a_lt_b = a < b;
        end
        // Strict compares: equal operands fall through to b with cond = 0.
        if (pick_max) begin
            res  = a_gt_b ? a : b;
            cond = a_gt_b;
        end else begin
            res  = a_lt_b ? a : b;
            cond = a_lt_b;
        end
    end

endmodule

// File: rtl/sclu_cntmm.sv
module sclu_cntmm
    import sclu_pkg::*;
#(
    parameter int WIDE   = 64,
    parameter int NARROW = 32,
    localparam int CW    = $clog2(WIDE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPW-1:0]    op,
    input  logic [WIDE-1:0]   src0,
    input  logic [NARROW-1:0] src1,
    output logic              out_valid,
    output logic [NARROW-1:0] dst,
    output logic              flag
);

    sclu_op_e          op_e;
    sclu_st_e          state, nxt_state;
    logic [WIDE-1:0]   cnt_vec;
    logic [CW-1:0]     cnt;
    logic [NARROW-1:0] mm_res;
    logic              mm_cond;
    logic [NARROW-1:0] nxt_dst;
    logic              nxt_flag;

    assign op_e = sclu_op_e'(op);

    // Operand shaping for the counter: narrow forms zero the upper half.
    always_comb begin
        unique case (op_e)
            OP_ONES_N:  cnt_vec = {{(WIDE-NARROW){1'b0}},  src0[NARROW-1:0]};
            OP_ONES_W:  cnt_vec = src0;
            OP_ZEROS_N: cnt_vec = {{(WIDE-NARROW){1'b0}}, ~src0[NARROW-1:0]};
            OP_ZEROS_W: cnt_vec = ~src0;
            default:    cnt_vec = '0;
        endcase
    end

    sclu_popcnt #(.W(WIDE), .LANE(8)) u_popcnt (
        .vec   (cnt_vec),
        .count (cnt)
    );

    sclu_minmax #(.W(NARROW)) u_minmax (
        .a          (src0[NARROW-1:0]),
        .b          (src1),
        .use_signed (~op[1]),
        .pick_max   (op[0]),
        .res        (mm_res),
        .cond       (mm_cond)
    );

    always_comb begin
        if (!op[2]) begin
            nxt_dst  = {{(NARROW-CW){1'b0}}, cnt};
            nxt_flag = (cnt != '0);
        end else begin
            nxt_dst  = mm_res;
            nxt_flag = mm_cond;
        end
    end

    // Next-state logic of the output-stage controller.
    always_comb begin
        unique case (state)
            ST_IDLE: nxt_state = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: nxt_state = in_valid ? ST_EMIT : ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // Result registers: load on an accepted operation, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst  <= '0;
            flag <= 1'b0;
        end else if (in_valid) begin
            dst  <= nxt_dst;
            flag <= nxt_flag;
        end
    end

    assign out_valid = (state == ST_EMIT);

endmodule

// File: rtl/sclu_cntmm_chk.sv
module sclu_cntmm_chk #(
    parameter int WIDE   = 64,
    parameter int NARROW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op,
    input logic [WIDE-1:0]   src0,
    input logic [NARROW-1:0] src1,
    input logic              out_valid,
    input logic [NARROW-1:0] dst,
    input logic              flag
);

    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r8_quiet_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dst) && $stable(flag)));

    a_r4_count_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op[2]) |=> (flag == (dst != '0)));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op[2]) |=> (dst <= NARROW'(WIDE)));

    a_r5_umax_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd7) |=> (dst >= $past(src1) && dst >= $past(src0[NARROW-1:0])));

    a_r6_umin_not_above: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd6) |=> (dst <= $past(src1) && dst <= $past(src0[NARROW-1:0])));

    a_r7_equal_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[2] && src0[NARROW-1:0] == src1) |=> !flag);

    always_comb begin
        if (!rst_n) begin
            a_r9_reset_quiet: assert (!out_valid || $isunknown(out_valid));
        end
    end

endmodule

bind sclu_cntmm sclu_cntmm_chk #(.WIDE(WIDE), .NARROW(NARROW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .src0      (src0),
    .src1      (src1),
    .out_valid (out_valid),
    .dst       (dst),
    .flag      (flag)
);

// File: tb/sclu_cntmm_test.sv
module sclu_cntmm_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] src0 = '0;
    logic [31:0] src1 = '0;
    logic        out_valid;
    logic [31:0] dst;
    logic        flag;

    int n_vec = 0;
    int n_bad = 0;
    logic        m_valid = 1'b0;
    logic [31:0] m_dst = '0;
    logic        m_flag = 1'b0;
    logic [2:0]  m_op = '0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    sclu_cntmm uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src0(src0), .src1(src1), .out_valid(out_valid), .dst(dst), .flag(flag)
    );

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4: return "R6";
            3'd5: return "R5";
            3'd6: return "R6/R7";
            default: return "R5/R7";
        endcase
    endfunction

    // Behavioural reference: one operation on the given operands.
    task automatic ref_op(input logic [2:0] o, input logic [63:0] a, input logic [31:0] b,
                          output logic [31:0] r, output logic f);
        int n;
        longint sa, sb;
        n = 0;
        if (o < 3'd4) begin
            for (int i = 0; i < ((o[0]) ? 64 : 32); i++)
                if (a[i] == !o[1]) n++;
            r = 32'(n);
            f = (n != 0);
        end else begin
            if (o[1]) begin sa = longint'({32'b0, a[31:0]}); sb = longint'({32'b0, b}); end
            else begin sa = longint'($signed(a[31:0])); sb = longint'($signed(b)); end
            if (o[0]) begin f = sa > sb; r = f ? a[31:0] : b; end
            else      begin f = sa < sb; r = f ? a[31:0] : b; end
        end
    endtask

    task automatic compare(input string tag);
        n_vec++;
        if (out_valid !== m_valid) begin
            n_bad++;
            $display("FAIL R8 out_valid actual=%0b expected=%0b", out_valid, m_valid);
        end
        if (dst !== m_dst || flag !== m_flag) begin
            n_bad++;
            $display("FAIL %s dst/flag actual=%h/%0b expected=%h/%0b", tag, dst, flag, m_dst, m_flag);
        end
    endtask

    task automatic step(input logic v, input logic [2:0] o, input logic [63:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic        f;
        in_valid = v; op = o; src0 = a; src1 = b;
        @(posedge clk);
        m_valid = v;
        if (v) begin
            ref_op(o, a, b, r, f);
            m_dst = r; m_flag = f; m_op = o;
        end
        @(negedge clk);
        compare(v ? tag_of(o) : "R10");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R9");                        // R9: reset state
        rst_n = 1'b1;
        // R1: upper-half garbage ignored by the 32-bit count
        step(1, 3'd0, 64'hFFFF_FFFF_0000_00F0, 32'h0);
        step(1, 3'd0, 64'hA5A5_A5A5_0000_0000, 32'h0);   // R4: zero count, flag 0
        step(1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0);   // R2: count 64
        step(1, 3'd3, 64'h0, 32'h0);                     // R3: 64 zeros
        step(1, 3'd2, 64'h1234_5678_FFFF_FFFF, 32'h0);   // R3: no zeros, flag 0
        step(1, 3'd2, 64'hFFFF_FFFF_0000_0001, 32'h0);   // R3: 31 zeros
        step(0, 3'd1, 64'h0, 32'h5);                     // R10: hold
        step(0, 3'd7, 64'hFFFF, 32'h5);                  // R10: hold
        step(1, 3'd5, 64'hFFFF_FFFF, 32'h1);             // R5/R7 signed max
        step(1, 3'd7, 64'hFFFF_FFFF, 32'h1);             // R5/R7 unsigned max
        step(1, 3'd4, 64'hFFFF_FFFF, 32'h1);             // R6/R7 signed min
        step(1, 3'd6, 64'hFFFF_FFFF, 32'h1);             // R6/R7 unsigned min
        step(1, 3'd5, 64'h8000_0000, 32'h8000_0000);     // R7 equal operands
        step(1, 3'd6, 64'h0000_0042, 32'h0000_0042);     // R7 equal operands
        step(1, 3'd4, 64'h7FFF_FFFF, 32'h8000_0000);     // R6 signed extremes
        for (int k = 0; k < 400; k++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            step(lfsr[60] | lfsr[61], lfsr[2:0], lfsr, lfsr[47:16] ^ (lfsr[62] ? lfsr[31:0] : 32'h0));
        end
        step(0, 3'd0, 64'h0, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule